// File: doc/BRIEF.md
# Issue Hazard Checker with Function-Unit Selection

This block sits at the head of an in-order issue stage. Each cycle it decides whether the instruction waiting there may start. The instruction comes with an operation kind, source and destination masks for the integer, floating-point and condition-field register classes, a special-register index, two candidate function units, and its issue and completion latencies. The block compares these against the busy state that an external reservation tracker reports. That state covers register masks, special-register flags, per-unit busy flags and an "in-flight table empty" indication.

When the instruction may start, the block raises `in_ready` and sends the tracker an allocate request in the same cycle. The request carries the chosen unit, both latencies, the destination masks to reserve, and the number of writeback slots the result will need. A small state machine remembers why the head is waiting. This lets the block leave the first cycle of a data or unit wait out of the count and still count every later cycle. Serializing instructions are handled separately: they wait for the tracker to drain completely.

The machine has four states:
- `S_HEAD`: a fresh instruction is being looked at.
- `S_DATA`: waiting on a register conflict.
- `S_UNIT`: waiting for a free unit.
- `S_DRAIN`: a serializing instruction is waiting for the table to empty.

Its transitions are:
- HEAD→DATA on a conflict.
- HEAD→UNIT when both units are busy.
- HEAD→DRAIN for a serializing instruction while the table is not empty.
- DATA→UNIT when the conflict clears but both units are busy.
- Any state→HEAD on an allocation or when `in_valid` drops.

Top module: `hz_issue_ctl`

## Requirements
- R1: A non-serializing instruction is held (`in_ready`=0) while a tracker busy bit overlaps the union of its source and destination masks in any register class its kind uses.
- R2: The first cycle that a fresh instruction is held by a register conflict does not advance `cnt_data`. Each later held cycle of that conflict adds exactly one.
- R3: Once conflicts clear, the instruction allocates on `in_unit_a` if it is free, otherwise on `in_unit_b` if that is free. If both are busy it waits. The first such wait cycle does not count, and every later one adds one to `cnt_unit`.
- R4: The writeback count for an integer destination is 0 if the mask is empty, 1 if exactly one bit is set and 2 if more than one is set. Kind 1 adds one if its condition-field destination is non-empty. Kind 2 gives 1 if its condition-field destination is non-empty, else 0.
- R5: Kind 3 gives a writeback count of 1. Kind 4 gives 2 with a non-empty condition-field destination, else 1. Kind 5 gives one per non-empty destination among integer and floating-point. Kinds 6 and 7 give 1.
- R6: A serializing instruction (`in_serial`=1) ignores register masks and unit flags. It waits until `trk_empty`=1, adding one to `cnt_ser` on every waiting cycle including the first. It then allocates on `in_unit_a` with empty reservation masks and a writeback count of 0.
- R7: The condition-field source is taken from `in_cr_src_bits`. Groups of 4 bits are scanned from the most significant end, and the first group holding a set bit gives field g. Field g is bit g of the condition-field masks, so group g covers bits [31-4g : 28-4g].
- R8: Kinds 6 and 7 are also held while `trk_spr_busy[in_spr_idx]` is set. Kind 7 reserves that special register (`alloc_spr_valid`=1). Kind 6 reserves its integer destination.
- R9: Kind encoding on `in_kind` is: 0 integer, 1 integer plus condition, 2 condition only, 3 float, 4 float plus condition, 5 integer plus float, 6 special-to-integer move, 7 integer-to-special move. Busy bits of a class that the kind does not use have no effect on issue. Integer masks are used by 0, 1, 5, 6 and 7, float masks by 3, 4 and 5, and condition masks by 1, 2 and 4.
- R10: `in_ready` and `alloc_valid` rise in the same cycle, and only while `in_valid` is high. The request repeats both latencies unchanged and reserves the destination masks of the classes the kind uses. After reset the counters are 0 and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head instruction present |
| in_ready | output | 1 | Head instruction issues this cycle |
| in_kind | input | 3 | Operation kind (R9 encoding) |
| in_serial | input | 1 | Serializing instruction |
| in_int_src | input | INT_N | Integer source mask |
| in_int_dst | input | INT_N | Integer destination mask |
| in_fp_src | input | FP_N | Float source mask |
| in_fp_dst | input | FP_N | Float destination mask |
| in_cr_src_bits | input | 4*CR_N | Condition bits read, one bit per CR bit |
| in_cr_dst | input | CR_N | Condition-field destination mask |
| in_spr_idx | input | SPR_W | Special register index |
| in_unit_a | input | UNIT_W | Preferred function unit |
| in_unit_b | input | UNIT_W | Alternate function unit |
| in_issue_lat | input | LAT_W | Cycles until the unit accepts again |
| in_done_lat | input | LAT_W | Cycles until the result completes |
| trk_int_busy | input | INT_N | Integer registers pending |
| trk_fp_busy | input | FP_N | Float registers pending |
| trk_cr_busy | input | CR_N | Condition fields pending |
| trk_spr_busy | input | SPR_N | Special registers pending |
| trk_unit_busy | input | UNIT_N | Function units occupied |
| trk_empty | input | 1 | No entry in flight |
| alloc_valid | output | 1 | Allocate request |
| alloc_unit | output | UNIT_W | Unit to occupy |
| alloc_issue_lat | output | LAT_W | Issue latency for the entry |
| alloc_done_lat | output | LAT_W | Completion latency for the entry |
| alloc_int | output | INT_N | Integer registers to reserve |
| alloc_fp | output | FP_N | Float registers to reserve |
| alloc_cr | output | CR_N | Condition fields to reserve |
| alloc_spr_valid | output | 1 | Reserve a special register |
| alloc_spr_idx | output | SPR_W | Special register to reserve |
| alloc_wb | output | 2 | Writeback slots needed |
| cnt_data | output | CNT_W | Register-conflict stall count |
| cnt_unit | output | CNT_W | Unit stall count |
| cnt_ser | output | CNT_W | Drain stall count |

## Verification
Random instructions are issued with a conflict held for a chosen number of cycles and each candidate unit kept busy for its own number of cycles. The issue cycle, the chosen unit and the counter increments then show whether the first wait cycle is skipped and whether unit A is preferred over unit B. Unused register classes are flooded with random busy bits on every cycle, which separates a kind-aware check from a check of all classes. Directed destination shapes (empty, one bit, several bits, with and without a condition field) separate the writeback rules per kind. Fixed condition-bit patterns with two set groups show that the scan takes the most significant group. Serializing instructions are run with random masks and busy units, which shows that only the drain state gates them and that every drain cycle is counted.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;

    localparam int WB_W = 2;

    typedef enum logic [2:0] {
        K_INT      = 3'd0,
        K_INT_CR   = 3'd1,
        K_CR       = 3'd2,
        K_FLT      = 3'd3,
        K_FLT_CR   = 3'd4,
        K_INT_FLT  = 3'd5,
        K_FROM_SPR = 3'd6,
        K_TO_SPR   = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        S_HEAD  = 2'd0,
        S_DATA  = 2'd1,
        S_UNIT  = 2'd2,
        S_DRAIN = 2'd3
    } st_e;

    // Which register classes a kind checks for conflicts and reserves.
    typedef struct packed {
        logic chk_int;
        logic chk_fp;
        logic chk_cr;
        logic chk_spr;
        logic rsv_int;
        logic rsv_fp;
        logic rsv_cr;
        logic rsv_spr;
    } use_t;

    function automatic use_t kind_use(kind_e k);
        use_t u;
        u = '0;
        unique case (k)
            K_INT:      begin u.chk_int = 1'b1; u.rsv_int = 1'b1; end
            K_INT_CR:   begin u.chk_int = 1'b1; u.rsv_int = 1'b1;
                              u.chk_cr  = 1'b1; u.rsv_cr  = 1'b1; end
            K_CR:       begin u.chk_cr  = 1'b1; u.rsv_cr  = 1'b1; end
            K_FLT:      begin u.chk_fp  = 1'b1; u.rsv_fp  = 1'b1; end
            K_FLT_CR:   begin u.chk_fp  = 1'b1; u.rsv_fp  = 1'b1;
                              u.chk_cr  = 1'b1; u.rsv_cr  = 1'b1; end
            K_INT_FLT:  begin u.chk_int = 1'b1; u.rsv_int = 1'b1;
                              u.chk_fp  = 1'b1; u.rsv_fp  = 1'b1; end
            K_FROM_SPR: begin u.chk_int = 1'b1; u.rsv_int = 1'b1;
                              u.chk_spr = 1'b1; end
            K_TO_SPR:   begin u.chk_int = 1'b1; u.chk_spr = 1'b1;
                              u.rsv_spr = 1'b1; end
        endcase
        return u;
    endfunction

endpackage

// File: rtl/hz_class_mask.sv
`timescale 1ns/1ps
module hz_class_mask
    import hz_pkg::*;
#(
    parameter int INT_N = 32,
    parameter int FP_N  = 32,
    parameter int CR_N  = 8
) (
    input  kind_e                 kind,
    input  logic [INT_N-1:0]      int_src,
    input  logic [INT_N-1:0]      int_dst,
    input  logic [FP_N-1:0]       fp_src,
    input  logic [FP_N-1:0]       fp_dst,
    input  logic [4*CR_N-1:0]     cr_src_bits,
    input  logic [CR_N-1:0]       cr_dst,
    output logic [INT_N-1:0]      chk_int,
    output logic [FP_N-1:0]       chk_fp,
    output logic [CR_N-1:0]       chk_cr,
    output logic                  chk_spr,
    output logic [INT_N-1:0]      rsv_int,
    output logic [FP_N-1:0]       rsv_fp,
    output logic [CR_N-1:0]       rsv_cr,
    output logic                  rsv_spr
);

    localparam int CR_BITS = 4 * CR_N;

    use_t             use_k;
    logic [CR_N-1:0]  grp_any;
    logic [CR_N-1:0]  cr_src_fld;
    logic             scan_hit;

    assign use_k = kind_use(kind);

    // Group g holds bits [CR_BITS-1-4g -: 4]; group 0 is the top nibble.
    for (genvar g = 0; g < CR_N; g++) begin : g_grp
        assign grp_any[g] = |cr_src_bits[CR_BITS-1-4*g -: 4];
    end

    // Priority scan from the most significant group downward.
    always_comb begin
        scan_hit   = 1'b0;
        cr_src_fld = '0;
        for (int g = 0; g < CR_N; g++) begin
            if (!scan_hit && grp_any[g]) begin
                scan_hit      = 1'b1;
                cr_src_fld[g] = 1'b1;
            end
        end
    end

    assign chk_int = use_k.chk_int ? (int_src | int_dst)   : '0;
    assign chk_fp  = use_k.chk_fp  ? (fp_src | fp_dst)     : '0;
    assign chk_cr  = use_k.chk_cr  ? (cr_src_fld | cr_dst) : '0;
    assign chk_spr = use_k.chk_spr;

    assign rsv_int = use_k.rsv_int ? int_dst : '0;
    assign rsv_fp  = use_k.rsv_fp  ? fp_dst  : '0;
    assign rsv_cr  = use_k.rsv_cr  ? cr_dst  : '0;
    assign rsv_spr = use_k.rsv_spr;

endmodule

// File: rtl/hz_wb_count.sv
`timescale 1ns/1ps
module hz_wb_count
    import hz_pkg::*;
#(
    parameter int INT_N = 32,
    parameter int FP_N  = 32,
    parameter int CR_N  = 8
) (
    input  kind_e             kind,
    input  logic [INT_N-1:0]  int_dst,
    input  logic [FP_N-1:0]   fp_dst,
    input  logic [CR_N-1:0]   cr_dst,
    output logic [WB_W-1:0]   wb
);

    logic            int_any;
    logic            int_multi;
    logic            fp_any;
    logic            cr_any;
    logic [WB_W-1:0] int_part;

    assign int_any   = |int_dst;
    // More than one bit set: clearing the lowest set bit leaves something.
    assign int_multi = |(int_dst & (int_dst - INT_N'(1)));
    assign fp_any    = |fp_dst;
    assign cr_any    = |cr_dst;

    always_comb begin
        int_part = int_multi ? WB_W'(2) : (int_any ? WB_W'(1) : WB_W'(0));
        wb       = '0;
        unique case (kind)
            K_INT:      wb = int_part;
            K_INT_CR:   wb = int_part + WB_W'(cr_any);
            K_CR:       wb = WB_W'(cr_any);
            K_FLT:      wb = WB_W'(1);
            K_FLT_CR:   wb = cr_any ? WB_W'(2) : WB_W'(1);
            K_INT_FLT:  wb = WB_W'(int_any) + WB_W'(fp_any);
            K_FROM_SPR: wb = WB_W'(1);
            K_TO_SPR:   wb = WB_W'(1);
        endcase
    end

endmodule

// File: rtl/hz_unit_pick.sv
`timescale 1ns/1ps
module hz_unit_pick #(
    parameter int UNIT_N = 8,
    parameter int UNIT_W = $clog2(UNIT_N)
) (
    input  logic [UNIT_N-1:0] unit_busy,
    input  logic [UNIT_W-1:0] unit_a,
    input  logic [UNIT_W-1:0] unit_b,
    output logic              any_free,
    output logic [UNIT_W-1:0] pick
);

    logic a_free;
    logic b_free;

    assign a_free   = !unit_busy[unit_a];
    assign b_free   = !unit_busy[unit_b];
    assign any_free = a_free | b_free;
    assign pick     = a_free ? unit_a : unit_b;

endmodule

// File: rtl/hz_issue_ctl.sv
`timescale 1ns/1ps
module hz_issue_ctl
    import hz_pkg::*;
#(
    parameter int INT_N  = 32,
    parameter int FP_N   = 32,
    parameter int CR_N   = 8,
    parameter int SPR_N  = 16,
    parameter int UNIT_N = 8,
    parameter int LAT_W  = 4,
    parameter int CNT_W  = 16,
    parameter int SPR_W  = $clog2(SPR_N),
    parameter int UNIT_W = $clog2(UNIT_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2:0]           in_kind,
    input  logic                 in_serial,
    input  logic [INT_N-1:0]     in_int_src,
    input  logic [INT_N-1:0]     in_int_dst,
    input  logic [FP_N-1:0]      in_fp_src,
    input  logic [FP_N-1:0]      in_fp_dst,
    input  logic [4*CR_N-1:0]    in_cr_src_bits,
    input  logic [CR_N-1:0]      in_cr_dst,
    input  logic [SPR_W-1:0]     in_spr_idx,
    input  logic [UNIT_W-1:0]    in_unit_a,
    input  logic [UNIT_W-1:0]    in_unit_b,
    input  logic [LAT_W-1:0]     in_issue_lat,
    input  logic [LAT_W-1:0]     in_done_lat,
    input  logic [INT_N-1:0]     trk_int_busy,
    input  logic [FP_N-1:0]      trk_fp_busy,
    input  logic [CR_N-1:0]      trk_cr_busy,
    input  logic [SPR_N-1:0]     trk_spr_busy,
    input  logic [UNIT_N-1:0]    trk_unit_busy,
    input  logic                 trk_empty,
    output logic                 alloc_valid,
    output logic [UNIT_W-1:0]    alloc_unit,
    output logic [LAT_W-1:0]     alloc_issue_lat,
    output logic [LAT_W-1:0]     alloc_done_lat,
    output logic [INT_N-1:0]     alloc_int,
    output logic [FP_N-1:0]      alloc_fp,
    output logic [CR_N-1:0]      alloc_cr,
    output logic                 alloc_spr_valid,
    output logic [SPR_W-1:0]     alloc_spr_idx,
    output logic [WB_W-1:0]      alloc_wb,
    output logic [CNT_W-1:0]     cnt_data,
    output logic [CNT_W-1:0]     cnt_unit,
    output logic [CNT_W-1:0]     cnt_ser
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    kind_e             kind;
    st_e               st_q;
    st_e               st_d;
    logic [INT_N-1:0]  chk_int;
    logic [FP_N-1:0]   chk_fp;
    logic [CR_N-1:0]   chk_cr;
    logic              chk_spr;
    logic [INT_N-1:0]  rsv_int;
    logic [FP_N-1:0]   rsv_fp;
    logic [CR_N-1:0]   rsv_cr;
    logic              rsv_spr;
    logic [WB_W-1:0]   wb_cnt;
    logic              unit_free;
    logic [UNIT_W-1:0] pick_unit;
    logic              conflict;
    logic              go;
    logic              inc_data;
    logic              inc_unit;
    logic              inc_ser;

    assign kind = kind_e'(in_kind);

    hz_class_mask #(
        .INT_N (INT_N),
        .FP_N  (FP_N),
        .CR_N  (CR_N)
    ) u_mask (
        .kind        (kind),
        .int_src     (in_int_src),
        .int_dst     (in_int_dst),
        .fp_src      (in_fp_src),
        .fp_dst      (in_fp_dst),
        .cr_src_bits (in_cr_src_bits),
        .cr_dst      (in_cr_dst),
        .chk_int     (chk_int),
        .chk_fp      (chk_fp),
        .chk_cr      (chk_cr),
        .chk_spr     (chk_spr),
        .rsv_int     (rsv_int),
        .rsv_fp      (rsv_fp),
        .rsv_cr      (rsv_cr),
        .rsv_spr     (rsv_spr)
    );

    hz_wb_count #(
        .INT_N (INT_N),
        .FP_N  (FP_N),
        .CR_N  (CR_N)
    ) u_wb (
        .kind    (kind),
        .int_dst (in_int_dst),
        .fp_dst  (in_fp_dst),
        .cr_dst  (in_cr_dst),
        .wb      (wb_cnt)
    );

    hz_unit_pick #(
        .UNIT_N (UNIT_N),
        .UNIT_W (UNIT_W)
    ) u_pick (
        .unit_busy (trk_unit_busy),
        .unit_a    (in_unit_a),
        .unit_b    (in_unit_b),
        .any_free  (unit_free),
        .pick      (pick_unit)
    );

    assign conflict = (|(trk_int_busy & chk_int))
                    | (|(trk_fp_busy  & chk_fp))
                    | (|(trk_cr_busy  & chk_cr))
                    | (chk_spr & trk_spr_busy[in_spr_idx]);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_HEAD;
        else        st_q <= st_d;
    end

    // Next state, issue decision and stall strobes.
    always_comb begin
        st_d     = st_q;
        go       = 1'b0;
        inc_data = 1'b0;
        inc_unit = 1'b0;
        inc_ser  = 1'b0;
        if (!in_valid) begin
            st_d = S_HEAD;
        end else begin
            unique case (st_q)
                S_HEAD: begin
                    if (in_serial) begin
                        if (trk_empty) go = 1'b1;
                        else begin
                            inc_ser = 1'b1;
                            st_d    = S_DRAIN;
                        end
                    end else if (conflict) begin
                        st_d = S_DATA;
                    end else if (unit_free) begin
                        go = 1'b1;
                    end else begin
                        st_d = S_UNIT;
                    end
                end
                S_DATA: begin
                    if (conflict)       inc_data = 1'b1;
                    else if (unit_free) go = 1'b1;
                    else                st_d = S_UNIT;
                end
                S_UNIT: begin
                    if (unit_free) go = 1'b1;
                    else           inc_unit = 1'b1;
                end
                S_DRAIN: begin
                    if (trk_empty) go = 1'b1;
                    else           inc_ser = 1'b1;
                end
            endcase
            if (go) st_d = S_HEAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_data <= '0;
            cnt_unit <= '0;
            cnt_ser  <= '0;
        end else begin
            if (inc_data) cnt_data <= cnt_data + CNT_ONE;
            if (inc_unit) cnt_unit <= cnt_unit + CNT_ONE;
            if (inc_ser)  cnt_ser  <= cnt_ser  + CNT_ONE;
        end
    end

    assign in_ready        = go;
    assign alloc_valid     = go;
    assign alloc_unit      = in_serial ? in_unit_a : pick_unit;
    assign alloc_issue_lat = in_issue_lat;
    assign alloc_done_lat  = in_done_lat;
    assign alloc_int       = in_serial ? '0 : rsv_int;
    assign alloc_fp        = in_serial ? '0 : rsv_fp;
    assign alloc_cr        = in_serial ? '0 : rsv_cr;
    assign alloc_spr_valid = in_serial ? 1'b0 : rsv_spr;
    assign alloc_spr_idx   = in_spr_idx;
    assign alloc_wb        = in_serial ? '0 : wb_cnt;

endmodule

// File: rtl/hz_issue_chk.sv
`timescale 1ns/1ps
module hz_issue_chk
    import hz_pkg::*;
#(
    parameter int INT_N  = 32,
    parameter int FP_N   = 32,
    parameter int CR_N   = 8,
    parameter int SPR_N  = 16,
    parameter int UNIT_N = 8,
    parameter int CNT_W  = 16,
    parameter int SPR_W  = $clog2(SPR_N),
    parameter int UNIT_W = $clog2(UNIT_N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [2:0]        in_kind,
    input logic              in_serial,
    input logic [SPR_W-1:0]  in_spr_idx,
    input logic [UNIT_W-1:0] in_unit_a,
    input logic [INT_N-1:0]  trk_int_busy,
    input logic [FP_N-1:0]   trk_fp_busy,
    input logic [CR_N-1:0]   trk_cr_busy,
    input logic [SPR_N-1:0]  trk_spr_busy,
    input logic [UNIT_N-1:0] trk_unit_busy,
    input logic              trk_empty,
    input logic              alloc_valid,
    input logic [UNIT_W-1:0] alloc_unit,
    input logic [INT_N-1:0]  alloc_int,
    input logic [FP_N-1:0]   alloc_fp,
    input logic [CR_N-1:0]   alloc_cr,
    input logic [WB_W-1:0]   alloc_wb,
    input logic [CNT_W-1:0]  cnt_data,
    input logic [CNT_W-1:0]  cnt_unit,
    input logic [CNT_W-1:0]  cnt_ser
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic spr_kind;
    assign spr_kind = (in_kind == 3'd6) || (in_kind == 3'd7);

    p_no_busy_dst_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && !in_serial |->
            ((trk_int_busy & alloc_int) == '0) && ((trk_fp_busy & alloc_fp) == '0)
            && ((trk_cr_busy & alloc_cr) == '0));

    p_data_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_data == $past(cnt_data)) || (cnt_data == $past(cnt_data) + ONE));

    p_first_wait_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || in_ready) ##1 (in_valid && !in_serial) |=>
            (cnt_data == $past(cnt_data)) && (cnt_unit == $past(cnt_unit)));

    p_unit_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && !in_serial |-> !trk_unit_busy[alloc_unit]);

    p_drain_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && in_serial |-> trk_empty && (alloc_unit == in_unit_a) && (alloc_wb == '0));

    p_drain_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_serial && !trk_empty |=> cnt_ser == $past(cnt_ser) + ONE);

    p_spr_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && !in_serial && spr_kind |-> !trk_spr_busy[in_spr_idx]);

    p_ready_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_valid && alloc_valid);

endmodule

bind hz_issue_ctl hz_issue_chk #(
    .INT_N  (INT_N),
    .FP_N   (FP_N),
    .CR_N   (CR_N),
    .SPR_N  (SPR_N),
    .UNIT_N (UNIT_N),
    .CNT_W  (CNT_W),
    .SPR_W  (SPR_W),
    .UNIT_W (UNIT_W)
) u_hz_issue_chk (.*);

// File: tb/test_hz_issue_ctl.sv
`timescale 1ns/1ps
module test_hz_issue_ctl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_kind;
    logic        in_serial;
    logic [31:0] in_int_src, in_int_dst, in_fp_src, in_fp_dst, in_cr_src_bits;
    logic [7:0]  in_cr_dst;
    logic [3:0]  in_spr_idx;
    logic [2:0]  in_unit_a, in_unit_b;
    logic [3:0]  in_issue_lat, in_done_lat;
    logic [31:0] trk_int_busy, trk_fp_busy;
    logic [7:0]  trk_cr_busy;
    logic [15:0] trk_spr_busy;
    logic [7:0]  trk_unit_busy;
    logic        trk_empty;
    logic        alloc_valid;
    logic [2:0]  alloc_unit;
    logic [3:0]  alloc_issue_lat, alloc_done_lat;
    logic [31:0] alloc_int, alloc_fp;
    logic [7:0]  alloc_cr;
    logic        alloc_spr_valid;
    logic [3:0]  alloc_spr_idx;
    logic [1:0]  alloc_wb;
    logic [15:0] cnt_data, cnt_unit, cnt_ser;

    int n_chk  = 0;
    int n_fail = 0;

    // Current instruction and its scenario
    int          i_kind;
    bit          i_ser;
    logic [31:0] i_isrc, i_idst, i_fsrc, i_fdst, i_crbits;
    logic [7:0]  i_crdst;
    logic [3:0]  i_spr;
    logic [2:0]  i_ua, i_ub;
    logic [3:0]  i_il, i_dl;
    int          i_d, i_u0, i_u1, i_e;

    always #4 clk = ~clk;   // 125 MHz

    hz_issue_ctl i_hz_issue_ctl (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit uses_int(int k); return k == 0 || k == 1 || k == 5 || k == 6 || k == 7; endfunction
    function automatic bit uses_fp(int k);  return k == 3 || k == 4 || k == 5; endfunction
    function automatic bit uses_cr(int k);  return k == 1 || k == 2 || k == 4; endfunction
    function automatic bit uses_spr(int k); return k == 6 || k == 7; endfunction

    // R7: first 4-bit group from the top holding a set bit
    function automatic logic [7:0] cr_field(logic [31:0] b);
        for (int g = 0; g < 8; g++)
            if (b[31-4*g -: 4] != 4'h0) return 8'(1) << g;
        return 8'h00;
    endfunction

    function automatic int exp_wb(int k, bit ser, logic [31:0] id, logic [31:0] fd, logic [7:0] cd);
        int iw;
        iw = (id == 0) ? 0 : (($countones(id) == 1) ? 1 : 2);
        if (ser) return 0;
        case (k)
            0: return iw;
            1: return iw + ((cd != 0) ? 1 : 0);
            2: return (cd != 0) ? 1 : 0;
            3: return 1;
            4: return (cd != 0) ? 2 : 1;
            5: return ((id != 0) ? 1 : 0) + ((fd != 0) ? 1 : 0);
            default: return 1;
        endcase
    endfunction

    task automatic apply_insn();
        in_valid       = 1'b1;
        in_kind        = 3'(i_kind);
        in_serial      = i_ser;
        in_int_src     = i_isrc;
        in_int_dst     = i_idst;
        in_fp_src      = i_fsrc;
        in_fp_dst      = i_fdst;
        in_cr_src_bits = i_crbits;
        in_cr_dst      = i_crdst;
        in_spr_idx     = i_spr;
        in_unit_a      = i_ua;
        in_unit_b      = i_ub;
        in_issue_lat   = i_il;
        in_done_lat    = i_dl;
    endtask

    // Tracker state for scenario cycle t: conflict for t < i_d, unit A busy for
    // t < i_u0, unit B busy for t < i_u1, table non-empty for t < i_e.
    task automatic drive_trk(input int t);
        logic [31:0] iu, fu;
        logic [7:0]  cu, ub;
        iu = i_isrc | i_idst;
        fu = i_fsrc | i_fdst;
        cu = i_crdst | cr_field(i_crbits);
        trk_int_busy = $urandom;
        trk_fp_busy  = $urandom;
        trk_cr_busy  = 8'($urandom);
        trk_spr_busy = 16'($urandom);
        if (!i_ser) begin
            if (uses_int(i_kind)) trk_int_busy &= ~iu;
            if (uses_fp(i_kind))  trk_fp_busy  &= ~fu;
            if (uses_cr(i_kind))  trk_cr_busy  &= ~cu;
            if (uses_spr(i_kind)) trk_spr_busy[i_spr] = 1'b0;
            if (t < i_d) begin
                if (uses_int(i_kind))     trk_int_busy |= iu;
                else if (uses_fp(i_kind)) trk_fp_busy  |= fu;
                else                      trk_cr_busy  |= cu;
            end
        end
        ub = 8'($urandom);
        if (!i_ser) begin
            ub[i_ua] = (t < i_u0);
            ub[i_ub] = (t < i_u1);
        end
        trk_unit_busy = ub;
        trk_empty     = i_ser ? (t >= i_e) : 1'($urandom);
    endtask

    task automatic run_one(input string tag);
        logic [15:0] cd0, cu0, cs0;
        int  t_exp, ex_d, ex_u, ex_s, t_hit;
        logic [2:0] u_exp;
        logic [31:0] e_int, e_fp;
        logic [7:0]  e_cr;
        bit hit;
        if (i_ser) begin
            t_exp = i_e; u_exp = i_ua; ex_d = 0; ex_u = 0; ex_s = i_e;
        end else begin
            t_exp = (i_u0 < i_u1) ? i_u0 : i_u1;
            if (i_d > t_exp) t_exp = i_d;
            u_exp = (t_exp >= i_u0) ? i_ua : i_ub;
            ex_d  = (i_d > 0) ? i_d - 1 : 0;
            ex_u  = (t_exp > i_d) ? t_exp - i_d - 1 : 0;
            ex_s  = 0;
        end
        e_int = (!i_ser && (i_kind inside {0, 1, 5, 6})) ? i_idst : 32'h0;
        e_fp  = (!i_ser && uses_fp(i_kind)) ? i_fdst : 32'h0;
        e_cr  = (!i_ser && uses_cr(i_kind)) ? i_crdst : 8'h0;
        @(negedge clk);
        cd0 = cnt_data; cu0 = cnt_unit; cs0 = cnt_ser;
        hit = 1'b0; t_hit = -1;
        for (int t = 0; t < 40 && !hit; t++) begin
            if (t > 0) @(negedge clk);
            apply_insn();
            drive_trk(t);
            #1;
            if (in_ready) begin
                hit = 1'b1; t_hit = t;
                chk(alloc_valid, "R10", {tag, " alloc with ready"}, alloc_valid, 1);
                chk(alloc_unit == u_exp, "R3", {tag, " unit"}, alloc_unit, u_exp);
                chk(alloc_wb == 2'(exp_wb(i_kind, i_ser, i_idst, i_fdst, i_crdst)), "R4", {tag, " wb (R5)"},
                    alloc_wb, exp_wb(i_kind, i_ser, i_idst, i_fdst, i_crdst));
                chk(alloc_int == e_int && alloc_fp == e_fp && alloc_cr == e_cr, "R10", {tag, " reserve"},
                    {alloc_cr, alloc_int}, {e_cr, e_int});
                chk(alloc_spr_valid == (!i_ser && i_kind == 7), "R8", {tag, " spr reserve"},
                    alloc_spr_valid, (!i_ser && i_kind == 7));
                chk(alloc_issue_lat == i_il && alloc_done_lat == i_dl, "R10", {tag, " latencies"},
                    {alloc_issue_lat, alloc_done_lat}, {i_il, i_dl});
            end
        end
        chk(t_hit == t_exp, i_ser ? "R6" : "R1", {tag, " issue cycle"}, t_hit, t_exp);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(cnt_data - cd0 == 16'(ex_d), "R2", {tag, " data stalls"}, cnt_data - cd0, ex_d);
        chk(cnt_unit - cu0 == 16'(ex_u), "R3", {tag, " unit stalls"}, cnt_unit - cu0, ex_u);
        chk(cnt_ser  - cs0 == 16'(ex_s), "R6", {tag, " drain stalls"}, cnt_ser - cs0, ex_s);
    endtask

    // Single-cycle look at in_ready with fixed tracker state.
    task automatic probe(input logic [31:0] ib, input logic [31:0] fb, input logic [7:0] cb,
                         input logic [15:0] sb, input bit exp, input string req, input string tag);
        @(negedge clk);
        apply_insn();
        trk_int_busy = ib; trk_fp_busy = fb; trk_cr_busy = cb; trk_spr_busy = sb;
        trk_unit_busy = 8'h00; trk_empty = 1'b1;
        #1;
        chk(in_ready == exp, req, tag, in_ready, exp);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_plain(input int k, input logic [31:0] id, input logic [31:0] fd, input logic [7:0] cd);
        i_kind = k; i_ser = 1'b0;
        i_isrc = 32'h0000_0010; i_idst = id;
        i_fsrc = 32'h0000_0100; i_fdst = fd;
        i_crbits = 32'h0; i_crdst = cd; i_spr = 4'd3;
        i_ua = 3'd1; i_ub = 3'd2; i_il = 4'd1; i_dl = 4'd3;
        i_d = 0; i_u0 = 0; i_u1 = 0; i_e = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_kind = 3'd0; in_serial = 1'b0;
        in_int_src = '0; in_int_dst = '0; in_fp_src = '0; in_fp_dst = '0;
        in_cr_src_bits = '0; in_cr_dst = '0; in_spr_idx = '0;
        in_unit_a = '0; in_unit_b = '0; in_issue_lat = '0; in_done_lat = '0;
        trk_int_busy = '0; trk_fp_busy = '0; trk_cr_busy = '0; trk_spr_busy = '0;
        trk_unit_busy = '0; trk_empty = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!in_ready && !alloc_valid, "R10", "reset no request", in_ready, 0);
        chk(cnt_data == 0 && cnt_unit == 0 && cnt_ser == 0, "R10", "reset counters",
            {cnt_data, cnt_unit, cnt_ser}, 0);

        // R4 integer shapes
        set_plain(0, 32'h0000_0004, 32'h0, 8'h0); run_one("R4 one dst");
        set_plain(0, 32'h0000_0006, 32'h0, 8'h0); run_one("R4 two dst");
        set_plain(0, 32'h0, 32'h0, 8'h0);         run_one("R4 no dst");
        set_plain(1, 32'h0000_0300, 32'h0, 8'h04); run_one("R4 int+cr");
        set_plain(2, 32'h0, 32'h0, 8'h0);         run_one("R4 cr empty");
        set_plain(2, 32'h0, 32'h0, 8'h80);        run_one("R4 cr one");
        // R5 float shapes
        set_plain(3, 32'h0, 32'h0000_0001, 8'h0);  run_one("R5 flt");
        set_plain(4, 32'h0, 32'h0000_0001, 8'h02); run_one("R5 flt+cr");
        set_plain(4, 32'h0, 32'h0000_0001, 8'h00); run_one("R5 flt no cr");
        set_plain(5, 32'h0000_0030, 32'h0000_0001, 8'h0); run_one("R5 int+flt");
        set_plain(5, 32'h0, 32'h0000_0001, 8'h0);  run_one("R5 flt only");
        set_plain(6, 32'h0000_0008, 32'h0, 8'h0);  run_one("R5 spr move");
        // R1 / R2 conflict lengths
        set_plain(0, 32'h1, 32'h0, 8'h0); i_d = 1; run_one("R2 one-cycle conflict");
        set_plain(0, 32'h1, 32'h0, 8'h0); i_d = 4; run_one("R2 four-cycle conflict");
        // R3 unit choice
        set_plain(0, 32'h1, 32'h0, 8'h0); i_u0 = 2; run_one("R3 alternate unit");
        set_plain(0, 32'h1, 32'h0, 8'h0); i_u0 = 3; i_u1 = 5; run_one("R3 both busy");
        set_plain(0, 32'h1, 32'h0, 8'h0); i_d = 2; i_u0 = 5; i_u1 = 5; run_one("R3 conflict then units");
        // R6 drain
        set_plain(1, 32'h1, 32'h0, 8'h1); i_ser = 1'b1; i_e = 3; run_one("R6 drain");
        set_plain(0, 32'h1, 32'h0, 8'h0); i_ser = 1'b1; i_e = 0; run_one("R6 empty already");

        // R7 scan: bits 24 and 8 set, top group wins -> field 1
        set_plain(2, 32'h0, 32'h0, 8'h0); i_crbits = 32'h0100_0100;
        probe('0, '0, 8'h20, '0, 1'b1, "R7", "lower group ignored");
        probe('0, '0, 8'h02, '0, 1'b0, "R7", "top group blocks");
        i_crbits = 32'h0000_0100;
        probe('0, '0, 8'h20, '0, 1'b0, "R7", "single group field 5");
        // R8 special register flag
        set_plain(7, 32'h0, 32'h0, 8'h0); i_spr = 4'd9;
        probe('0, '0, '0, 16'h0200, 1'b0, "R8", "own spr busy");
        probe('0, '0, '0, 16'hFDFF, 1'b1, "R8", "other sprs busy");
        // R9 unused classes
        set_plain(0, 32'h1, 32'h1, 8'h1); i_crbits = 32'hFFFF_FFFF;
        probe(32'h0, 32'hFFFF_FFFF, 8'hFF, 16'hFFFF, 1'b1, "R9", "int kind ignores fp/cr/spr");
        set_plain(3, 32'h1, 32'h1, 8'h1);
        probe(32'hFFFF_FFFF, 32'h0, 8'hFF, '0, 1'b1, "R9", "flt kind ignores int/cr");
        probe(32'h0, 32'h0000_0100, 8'h0, '0, 1'b0, "R1", "flt source busy");

        // Random mix
        for (int n = 0; n < 80; n++) begin
            i_kind = int'($urandom_range(0, 7));
            i_ser  = ($urandom_range(0, 7) == 0);
            i_isrc = $urandom | (32'h1 << $urandom_range(0, 31));
            case ($urandom_range(0, 2))
                0: i_idst = 32'h0;
                1: i_idst = 32'h1 << $urandom_range(0, 31);
                default: i_idst = $urandom;
            endcase
            i_fsrc   = $urandom | (32'h1 << $urandom_range(0, 31));
            i_fdst   = ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom;
            i_crbits = ($urandom_range(0, 1) == 0) ? 32'h0 : (32'h1 << $urandom_range(0, 31));
            i_crdst  = ($urandom_range(0, 1) == 0) ? 8'h0 : (8'h1 << $urandom_range(0, 7));
            i_spr    = 4'($urandom);
            i_ua     = 3'($urandom);
            i_ub     = i_ua + 3'($urandom_range(1, 7));
            i_il     = 4'($urandom);
            i_dl     = 4'($urandom);
            i_d      = $urandom_range(0, 4);
            i_u0     = $urandom_range(0, 4);
            i_u1     = $urandom_range(0, 4);
            i_e      = $urandom_range(0, 4);
            if (!uses_int(i_kind) && !uses_fp(i_kind) && (i_crdst | cr_field(i_crbits)) == 8'h0)
                i_d = 0;
            run_one("R1 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule